// File: doc/BRIEF.md
# Dual-Processor Mailbox with Hardware Locks

This block lets two processors, called side A and side B, pass short messages to each other and share resources safely. Each side has its own single-cycle register port and its own interrupt line. The block holds four message slots. Each slot has a command word and a payload word, and one processor owns each slot as its sender. The lower `A_TX_ELEMS` slots carry traffic from A to B. The remaining slots carry traffic from B to A. The sender writes the payload word first and the command word last. Writing the command word raises the slot's pending flag, and that flag can interrupt the receiving processor. The receiver reads both words, then clears the flag through its pending register.

Alongside the slots sits a bank of 32 hardware locks. A read of a lock both tests it and claims it in one bus access, so no read-modify-write sequence is needed. Any write to a lock frees it. When both sides claim the same free lock in the same cycle, side A always gets it.

Word address map (`ADDR_W` = 6): slot e command at 2e, slot e payload at 2e+1, pending register at 0x10, interrupt-enable register at 0x11, lock i at 0x20+i.

Top module: `ipc_mailbox`

## Requirements
- R1: A synchronous reset clears all pending flags, all interrupt enables, all locks, both interrupt outputs and both read-valid outputs. Command and payload words keep their contents.
- R2: A read strobe in cycle n returns the addressed word on that side's read data in cycle n+1, with read-valid high in exactly that cycle. Both sides can read every slot's command word and payload word.
- R3: When the owning sender writes a slot's command word (address 2e), that slot's pending flag is set. Writing the payload word (address 2e+1) leaves the flag unchanged.
- R4: Only side A can write slots 0..A_TX_ELEMS-1, and only side B can write the rest. A write from the other side changes neither word nor flag.
- R5: In the pending register (0x10), bit e shows slot e's flag, but only for slots the reading side receives. Other bits read 0. Writing a 1 to bit e clears the flag only when the writing side receives slot e. If a set and a clear hit the same flag in the same cycle, the set wins.
- R6: In the enable register (0x11), bit e is the enable for slot e and is held only for slots the side receives. A side's interrupt output is registered: it goes high one cycle after any received slot has both its flag and its enable set, and goes low one cycle after none has.
- R7: Reading a free lock (0x20+i) returns 0 and marks the lock taken at that clock edge.
- R8: Reading a taken lock returns 1 and leaves the lock taken.
- R9: A write of any value from either side to a lock address frees that lock.
- R10: If both sides read the same free lock in the same cycle, side A reads 0 and side B reads 1, and the lock ends up taken.
- R11: Reads of unmapped addresses return 0. Writes to unmapped addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_rd_en | input | 1 | Side A read strobe |
| a_wr_en | input | 1 | Side A write strobe |
| a_addr | input | ADDR_W | Side A word address |
| a_wdata | input | DATA_W | Side A write data |
| a_rdata | output | DATA_W | Side A registered read data |
| a_rvalid | output | 1 | Side A read data valid |
| irq_a | output | 1 | Interrupt to side A |
| b_rd_en | input | 1 | Side B read strobe |
| b_wr_en | input | 1 | Side B write strobe |
| b_addr | input | ADDR_W | Side B word address |
| b_wdata | input | DATA_W | Side B write data |
| b_rdata | output | DATA_W | Side B registered read data |
| b_rvalid | output | 1 | Side B read data valid |
| irq_b | output | 1 | Interrupt to side B |

## Verification
Messages are sent in both directions. This shows that each slot is tied to the correct sender and receiver, and that a payload write leaves the flag alone while a command write raises it. Writes from the wrong side, to slots and to the pending register, separate real ownership checks from plain address decode. A flag set and clear in the same cycle shows that the set takes priority. Lock traffic walks through free, taken, released and contested states, including both sides claiming the same lock in one cycle. A reset issued in the middle of the run shows which state the reset clears and which state it keeps.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  // low offsets inside the control window (upper address bits = 2'b01)
  localparam int unsigned OFS_PEND = 0;
  localparam int unsigned OFS_IEN  = 1;

  // mask with the n lowest bits set
  function automatic logic [31:0] low_mask(input int n);
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < 32; i++) begin
      if (i < n) m[i] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/mbx_addr_dec.sv
module mbx_addr_dec #(
  parameter int ADDR_W   = 6,
  parameter int NUM_ELEM = 4,
  parameter int NUM_LOCK = 32,
  parameter int EIDX_W   = 2,
  parameter int LIDX_W   = 5
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              elem_hit,
  output logic              is_data,
  output logic [EIDX_W-1:0] elem_idx,
  output logic              pend_hit,
  output logic              ien_hit,
  output logic              lock_hit,
  output logic [LIDX_W-1:0] lock_idx
);
  localparam int SLOT_W = ADDR_W - 3;

  logic [SLOT_W-1:0] slot;
  logic [ADDR_W-2:0] lock_ofs;
  logic [ADDR_W-3:0] ctl_ofs;

  always_comb begin
    slot     = addr[ADDR_W-3:1];
    lock_ofs = addr[ADDR_W-2:0];
    ctl_ofs  = addr[ADDR_W-3:0];
    elem_hit = (addr[ADDR_W-1:ADDR_W-2] == 2'b00) && (int'(slot) < NUM_ELEM);
    is_data  = addr[0];
    elem_idx = slot[EIDX_W-1:0];
    pend_hit = (addr[ADDR_W-1:ADDR_W-2] == 2'b01) && (int'(ctl_ofs) == mbx_pkg::OFS_PEND);
    ien_hit  = (addr[ADDR_W-1:ADDR_W-2] == 2'b01) && (int'(ctl_ofs) == mbx_pkg::OFS_IEN);
    lock_hit = addr[ADDR_W-1] && (int'(lock_ofs) < NUM_LOCK);
    lock_idx = lock_ofs[LIDX_W-1:0];
  end
endmodule

// File: rtl/mbx_msg_bank.sv
module mbx_msg_bank #(
  parameter int DATA_W     = 32,
  parameter int NUM_ELEM   = 4,
  parameter int A_TX_ELEMS = 2,
  parameter int EIDX_W     = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                a_wr,
  input  logic                a_elem_hit,
  input  logic                a_is_data,
  input  logic [EIDX_W-1:0]   a_elem,
  input  logic                a_pend_hit,
  input  logic                a_ien_hit,
  input  logic [DATA_W-1:0]   a_wdata,
  input  logic                b_wr,
  input  logic                b_elem_hit,
  input  logic                b_is_data,
  input  logic [EIDX_W-1:0]   b_elem,
  input  logic                b_pend_hit,
  input  logic                b_ien_hit,
  input  logic [DATA_W-1:0]   b_wdata,
  output logic [DATA_W-1:0]   a_elem_rd,
  output logic [DATA_W-1:0]   b_elem_rd,
  output logic [NUM_ELEM-1:0] a_pend_rd,
  output logic [NUM_ELEM-1:0] b_pend_rd,
  output logic [NUM_ELEM-1:0] a_ien_rd,
  output logic [NUM_ELEM-1:0] b_ien_rd,
  output logic [NUM_ELEM-1:0] flags,
  output logic [NUM_ELEM-1:0] ien,
  output logic                irq_a,
  output logic                irq_b
);
  // bit e set: slot e is sent by A and received by B
  localparam logic [NUM_ELEM-1:0] A_TX = NUM_ELEM'(mbx_pkg::low_mask(A_TX_ELEMS));
  localparam logic [NUM_ELEM-1:0] A_RX = ~A_TX;

  logic [DATA_W-1:0]   cmd_mem [NUM_ELEM];
  logic [DATA_W-1:0]   pay_mem [NUM_ELEM];
  logic [NUM_ELEM-1:0] wr_cmd, wr_pay, set_f, clr_f, ien_we;
  logic [NUM_ELEM-1:0] ien_val;
  logic [DATA_W-1:0]   src_wd [NUM_ELEM];
  logic [NUM_ELEM-1:0] flag_q, ien_q;

  for (genvar e = 0; e < NUM_ELEM; e++) begin : g_slot
    if (e < A_TX_ELEMS) begin : g_from_a
      always_comb begin
        wr_cmd[e]  = a_wr && a_elem_hit && (int'(a_elem) == e) && !a_is_data;
        wr_pay[e]  = a_wr && a_elem_hit && (int'(a_elem) == e) &&  a_is_data;
        src_wd[e]  = a_wdata;
        clr_f[e]   = b_wr && b_pend_hit && b_wdata[e];
        ien_we[e]  = b_wr && b_ien_hit;
        ien_val[e] = b_wdata[e];
      end
    end else begin : g_from_b
      always_comb begin
        wr_cmd[e]  = b_wr && b_elem_hit && (int'(b_elem) == e) && !b_is_data;
        wr_pay[e]  = b_wr && b_elem_hit && (int'(b_elem) == e) &&  b_is_data;
        src_wd[e]  = b_wdata;
        clr_f[e]   = a_wr && a_pend_hit && a_wdata[e];
        ien_we[e]  = a_wr && a_ien_hit;
        ien_val[e] = a_wdata[e];
      end
    end
    assign set_f[e] = wr_cmd[e];
  end

  // message words: no reset, so the arrays map onto plain storage
  always_ff @(posedge clk) begin
    for (int e = 0; e < NUM_ELEM; e++) begin
      if (wr_cmd[e]) cmd_mem[e] <= src_wd[e];
      if (wr_pay[e]) pay_mem[e] <= src_wd[e];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= '0;
      ien_q  <= '0;
      irq_a  <= 1'b0;
      irq_b  <= 1'b0;
    end else begin
      flag_q <= set_f | (flag_q & ~clr_f);
      for (int e = 0; e < NUM_ELEM; e++) begin
        if (ien_we[e]) ien_q[e] <= ien_val[e];
      end
      irq_a <= |(flag_q & ien_q & A_RX);
      irq_b <= |(flag_q & ien_q & A_TX);
    end
  end

  always_comb begin
    a_elem_rd = a_is_data ? pay_mem[a_elem] : cmd_mem[a_elem];
    b_elem_rd = b_is_data ? pay_mem[b_elem] : cmd_mem[b_elem];
    a_pend_rd = flag_q & A_RX;
    b_pend_rd = flag_q & A_TX;
    a_ien_rd  = ien_q & A_RX;
    b_ien_rd  = ien_q & A_TX;
    flags     = flag_q;
    ien       = ien_q;
  end
endmodule

// File: rtl/mbx_lock_bank.sv
module mbx_lock_bank #(
  parameter int NUM_LOCK = 32,
  parameter int LIDX_W   = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                a_acq,
  input  logic                a_rel,
  input  logic [LIDX_W-1:0]   a_idx,
  input  logic                b_acq,
  input  logic                b_rel,
  input  logic [LIDX_W-1:0]   b_idx,
  output logic                a_bit,
  output logic                b_bit,
  output logic [NUM_LOCK-1:0] locks
);
  logic [NUM_LOCK-1:0] lock_q, lock_d;

  for (genvar i = 0; i < NUM_LOCK; i++) begin : g_lock
    logic take, drop;
    always_comb begin
      take = (a_acq && (int'(a_idx) == i)) || (b_acq && (int'(b_idx) == i));
      drop = (a_rel && (int'(a_idx) == i)) || (b_rel && (int'(b_idx) == i));
      // a free lock is claimed by any read; a taken lock only falls on a write
      lock_d[i] = lock_q[i] ? !drop : take;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) lock_q <= '0;
    else     lock_q <= lock_d;
  end

  always_comb begin
    a_bit = lock_q[a_idx];
    // side A has priority on a same-cycle claim of the same lock
    b_bit = lock_q[b_idx] | (a_acq && (a_idx == b_idx));
    locks = lock_q;
  end
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox #(
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 32,
  parameter int NUM_ELEM   = 4,
  parameter int A_TX_ELEMS = 2,
  parameter int NUM_LOCK   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              a_rd_en,
  input  logic              a_wr_en,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  output logic              a_rvalid,
  output logic              irq_a,
  input  logic              b_rd_en,
  input  logic              b_wr_en,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata,
  output logic              b_rvalid,
  output logic              irq_b
);
  localparam int EIDX_W = (NUM_ELEM > 1) ? $clog2(NUM_ELEM) : 1;
  localparam int LIDX_W = (NUM_LOCK > 1) ? $clog2(NUM_LOCK) : 1;

  logic              a_elem_hit, a_is_data, a_pend_hit, a_ien_hit, a_lock_hit;
  logic              b_elem_hit, b_is_data, b_pend_hit, b_ien_hit, b_lock_hit;
  logic [EIDX_W-1:0] a_elem, b_elem;
  logic [LIDX_W-1:0] a_lidx, b_lidx;

  mbx_addr_dec #(.ADDR_W(ADDR_W), .NUM_ELEM(NUM_ELEM), .NUM_LOCK(NUM_LOCK),
                 .EIDX_W(EIDX_W), .LIDX_W(LIDX_W)) u_dec_a (
    .addr(a_addr), .elem_hit(a_elem_hit), .is_data(a_is_data), .elem_idx(a_elem),
    .pend_hit(a_pend_hit), .ien_hit(a_ien_hit), .lock_hit(a_lock_hit), .lock_idx(a_lidx));

  mbx_addr_dec #(.ADDR_W(ADDR_W), .NUM_ELEM(NUM_ELEM), .NUM_LOCK(NUM_LOCK),
                 .EIDX_W(EIDX_W), .LIDX_W(LIDX_W)) u_dec_b (
    .addr(b_addr), .elem_hit(b_elem_hit), .is_data(b_is_data), .elem_idx(b_elem),
    .pend_hit(b_pend_hit), .ien_hit(b_ien_hit), .lock_hit(b_lock_hit), .lock_idx(b_lidx));

  logic [DATA_W-1:0]   a_elem_rd, b_elem_rd;
  logic [NUM_ELEM-1:0] a_pend_rd, b_pend_rd, a_ien_rd, b_ien_rd;
  logic [NUM_ELEM-1:0] flags, irq_en;

  mbx_msg_bank #(.DATA_W(DATA_W), .NUM_ELEM(NUM_ELEM), .A_TX_ELEMS(A_TX_ELEMS),
                 .EIDX_W(EIDX_W)) u_msg (
    .clk(clk), .rst(rst),
    .a_wr(a_wr_en), .a_elem_hit(a_elem_hit), .a_is_data(a_is_data), .a_elem(a_elem),
    .a_pend_hit(a_pend_hit), .a_ien_hit(a_ien_hit), .a_wdata(a_wdata),
    .b_wr(b_wr_en), .b_elem_hit(b_elem_hit), .b_is_data(b_is_data), .b_elem(b_elem),
    .b_pend_hit(b_pend_hit), .b_ien_hit(b_ien_hit), .b_wdata(b_wdata),
    .a_elem_rd(a_elem_rd), .b_elem_rd(b_elem_rd),
    .a_pend_rd(a_pend_rd), .b_pend_rd(b_pend_rd),
    .a_ien_rd(a_ien_rd), .b_ien_rd(b_ien_rd),
    .flags(flags), .ien(irq_en), .irq_a(irq_a), .irq_b(irq_b));

  logic                a_lock_bit, b_lock_bit;
  logic [NUM_LOCK-1:0] locks;

  mbx_lock_bank #(.NUM_LOCK(NUM_LOCK), .LIDX_W(LIDX_W)) u_lock (
    .clk(clk), .rst(rst),
    .a_acq(a_rd_en && a_lock_hit), .a_rel(a_wr_en && a_lock_hit), .a_idx(a_lidx),
    .b_acq(b_rd_en && b_lock_hit), .b_rel(b_wr_en && b_lock_hit), .b_idx(b_lidx),
    .a_bit(a_lock_bit), .b_bit(b_lock_bit), .locks(locks));

  logic [DATA_W-1:0] a_rd_mux, b_rd_mux;

  always_comb begin
    a_rd_mux = '0;
    if (a_elem_hit)      a_rd_mux = a_elem_rd;
    else if (a_pend_hit) a_rd_mux = DATA_W'(a_pend_rd);
    else if (a_ien_hit)  a_rd_mux = DATA_W'(a_ien_rd);
    else if (a_lock_hit) a_rd_mux = DATA_W'(a_lock_bit);
    b_rd_mux = '0;
    if (b_elem_hit)      b_rd_mux = b_elem_rd;
    else if (b_pend_hit) b_rd_mux = DATA_W'(b_pend_rd);
    else if (b_ien_hit)  b_rd_mux = DATA_W'(b_ien_rd);
    else if (b_lock_hit) b_rd_mux = DATA_W'(b_lock_bit);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_rdata  <= '0;
      b_rdata  <= '0;
      a_rvalid <= 1'b0;
      b_rvalid <= 1'b0;
    end else begin
      a_rvalid <= a_rd_en;
      b_rvalid <= b_rd_en;
      if (a_rd_en) a_rdata <= a_rd_mux;
      if (b_rd_en) b_rdata <= b_rd_mux;
    end
  end
endmodule

// File: rtl/mbx_checker.sv
module mbx_checker #(
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 32,
  parameter int NUM_ELEM   = 4,
  parameter int A_TX_ELEMS = 2,
  parameter int NUM_LOCK   = 32
) (
  input logic                clk,
  input logic                rst,
  input logic                a_rd_en,
  input logic                a_wr_en,
  input logic [ADDR_W-1:0]   a_addr,
  input logic [DATA_W-1:0]   a_rdata,
  input logic                a_rvalid,
  input logic                irq_a,
  input logic                b_rd_en,
  input logic                b_wr_en,
  input logic [ADDR_W-1:0]   b_addr,
  input logic [DATA_W-1:0]   b_rdata,
  input logic                b_rvalid,
  input logic                irq_b,
  input logic [NUM_ELEM-1:0] flags,
  input logic [NUM_ELEM-1:0] irq_en,
  input logic [NUM_LOCK-1:0] locks
);
  localparam int LIDX_W = (NUM_LOCK > 1) ? $clog2(NUM_LOCK) : 1;
  localparam logic [NUM_ELEM-1:0] A_TX = NUM_ELEM'(mbx_pkg::low_mask(A_TX_ELEMS));

  logic              a_lk, b_lk, a_cmd;
  logic [LIDX_W-1:0] a_li, b_li;
  logic [ADDR_W-4:0] a_slot;

  always_comb begin
    a_lk   = a_addr[ADDR_W-1] && (int'(a_addr[ADDR_W-2:0]) < NUM_LOCK);
    b_lk   = b_addr[ADDR_W-1] && (int'(b_addr[ADDR_W-2:0]) < NUM_LOCK);
    a_li   = a_addr[LIDX_W-1:0];
    b_li   = b_addr[LIDX_W-1:0];
    a_slot = a_addr[ADDR_W-3:1];
    a_cmd  = a_wr_en && (a_addr[ADDR_W-1:ADDR_W-2] == 2'b00) && !a_addr[0]
             && (int'(a_slot) < A_TX_ELEMS);
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!irq_a && !irq_b && !a_rvalid && !b_rvalid && flags == '0 && locks == '0));

  a_r2_rvalid_a: assert property (@(posedge clk) disable iff (rst)
    a_rd_en |=> a_rvalid);

  a_r2_rvalid_b: assert property (@(posedge clk) disable iff (rst)
    !b_rd_en |=> !b_rvalid);

  a_r3_cmd_sets_flag: assert property (@(posedge clk) disable iff (rst)
    a_cmd |=> flags[$past(a_slot)]);

  a_r6_irq_a_off: assert property (@(posedge clk) disable iff (rst)
    ((flags & irq_en & ~A_TX) == '0) |=> !irq_a);

  a_r6_irq_b_off: assert property (@(posedge clk) disable iff (rst)
    ((flags & irq_en & A_TX) == '0) |=> !irq_b);

  a_r7_claim_free: assert property (@(posedge clk) disable iff (rst)
    (a_rd_en && a_lk && !locks[a_li]) |=> (a_rdata == '0 && locks[$past(a_li)]));

  a_r8_taken_reads_one: assert property (@(posedge clk) disable iff (rst)
    (b_rd_en && b_lk && locks[b_li] && !(a_wr_en && a_addr == b_addr))
      |=> (b_rdata == DATA_W'(1) && locks[$past(b_li)]));

  a_r10_tie_a_wins: assert property (@(posedge clk) disable iff (rst)
    (a_rd_en && b_rd_en && a_lk && a_addr == b_addr && !locks[a_li])
      |=> (a_rdata == '0 && b_rdata == DATA_W'(1)));
endmodule

bind ipc_mailbox mbx_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_ELEM(NUM_ELEM),
  .A_TX_ELEMS(A_TX_ELEMS), .NUM_LOCK(NUM_LOCK)
) u_chk (
  .clk(clk), .rst(rst),
  .a_rd_en(a_rd_en), .a_wr_en(a_wr_en), .a_addr(a_addr), .a_rdata(a_rdata),
  .a_rvalid(a_rvalid), .irq_a(irq_a),
  .b_rd_en(b_rd_en), .b_wr_en(b_wr_en), .b_addr(b_addr), .b_rdata(b_rdata),
  .b_rvalid(b_rvalid), .irq_b(irq_b),
  .flags(flags), .irq_en(irq_en), .locks(locks)
);

// File: tb/tb_ipc_mailbox.sv
module tb_ipc_mailbox;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        a_rd_en = 0, a_wr_en = 0, b_rd_en = 0, b_wr_en = 0;
  logic [5:0]  a_addr = '0, b_addr = '0;
  logic [31:0] a_wdata = '0, b_wdata = '0;
  logic [31:0] a_rdata, b_rdata;
  logic        a_rvalid, b_rvalid, irq_a, irq_b;

  always #5 clk = ~clk;

  ipc_mailbox dut (
    .clk(clk), .rst(rst),
    .a_rd_en(a_rd_en), .a_wr_en(a_wr_en), .a_addr(a_addr), .a_wdata(a_wdata),
    .a_rdata(a_rdata), .a_rvalid(a_rvalid), .irq_a(irq_a),
    .b_rd_en(b_rd_en), .b_wr_en(b_wr_en), .b_addr(b_addr), .b_wdata(b_wdata),
    .b_rdata(b_rdata), .b_rvalid(b_rvalid), .irq_b(irq_b));

  int n_chk = 0;
  int n_fail = 0;

  typedef struct packed {
    logic        sb;   // 0 = side A, 1 = side B
    logic        wr;   // 1 = write, 0 = read and check
    logic [5:0]  ad;
    logic [31:0] wd;
    logic [31:0] ex;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b1, 6'h01, 32'hDEAD0001, 32'h0,        4'd2 },  // R2 payload slot0
    '{1'b1, 1'b0, 6'h10, 32'h0,        32'h0,        4'd3 },  // R3 payload sets no flag
    '{1'b0, 1'b1, 6'h00, 32'h000000C0, 32'h0,        4'd3 },  // R3 command slot0
    '{1'b1, 1'b0, 6'h10, 32'h0,        32'h1,        4'd3 },  // R3 flag seen by B
    '{1'b1, 1'b0, 6'h01, 32'h0,        32'hDEAD0001, 4'd2 },  // R2 B reads payload
    '{1'b0, 1'b0, 6'h00, 32'h0,        32'h000000C0, 4'd2 },  // R2 A reads command
    '{1'b1, 1'b1, 6'h00, 32'h55,       32'h0,        4'd4 },  // R4 B write to A slot
    '{1'b1, 1'b0, 6'h00, 32'h0,        32'h000000C0, 4'd4 },  // R4 unchanged
    '{1'b0, 1'b0, 6'h10, 32'h0,        32'h0,        4'd5 },  // R5 A sees no B-rx bits
    '{1'b0, 1'b1, 6'h10, 32'hF,        32'h0,        4'd5 },  // R5 A cannot clear slot0
    '{1'b1, 1'b0, 6'h10, 32'h0,        32'h1,        4'd5 },  // R5 still set
    '{1'b1, 1'b1, 6'h10, 32'h1,        32'h0,        4'd5 },  // R5 B clears
    '{1'b1, 1'b0, 6'h10, 32'h0,        32'h0,        4'd5 },  // R5 cleared
    '{1'b1, 1'b1, 6'h06, 32'h33,       32'h0,        4'd3 },  // R3 B command slot3
    '{1'b0, 1'b0, 6'h10, 32'h0,        32'h8,        4'd3 },  // R3 A sees bit3
    '{1'b0, 1'b1, 6'h06, 32'h77,       32'h0,        4'd4 },  // R4 A write to B slot
    '{1'b0, 1'b0, 6'h06, 32'h0,        32'h33,       4'd4 },  // R4 unchanged
    '{1'b0, 1'b0, 6'h12, 32'h0,        32'h0,        4'd11},  // R11 unmapped
    '{1'b0, 1'b0, 6'h25, 32'h0,        32'h0,        4'd7 },  // R7 claim free
    '{1'b1, 1'b0, 6'h25, 32'h0,        32'h1,        4'd8 },  // R8 taken
    '{1'b0, 1'b0, 6'h25, 32'h0,        32'h1,        4'd8 },  // R8 taken, owner too
    '{1'b1, 1'b1, 6'h25, 32'h0,        32'h0,        4'd9 },  // R9 B releases
    '{1'b1, 1'b0, 6'h25, 32'h0,        32'h0,        4'd9 },  // R9 free again
    '{1'b1, 1'b1, 6'h25, 32'h0,        32'h0,        4'd9 }   // R9 release
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle_all();
    a_rd_en = 0; a_wr_en = 0; b_rd_en = 0; b_wr_en = 0;
  endtask

  task automatic cyc();
    @(negedge clk);
    idle_all();
  endtask

  task automatic drive(input logic sb, input logic wr, input logic [5:0] ad, input logic [31:0] wd);
    if (!sb) begin a_addr = ad; a_wdata = wd; a_wr_en = wr; a_rd_en = !wr; end
    else     begin b_addr = ad; b_wdata = wd; b_wr_en = wr; b_rd_en = !wr; end
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 irq_a", {31'b0, irq_a}, 32'h0);
    check("R1 irq_b", {31'b0, irq_b}, 32'h0);
    check("R1 rvalid", {30'b0, a_rvalid, b_rvalid}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].sb, VEC[i].wr, VEC[i].ad, VEC[i].wd);
      cyc();
      if (!VEC[i].wr)
        check($sformatf("R%0d vec%0d", VEC[i].rq, i),
              VEC[i].sb ? b_rdata : a_rdata, VEC[i].ex);
    end

    // R6: slot3 flag set for A but enable off
    check("R6 irq_a disabled", {31'b0, irq_a}, 32'h0);
    drive(0, 1, 6'h11, 32'hF); cyc();
    drive(0, 0, 6'h11, 32'h0); cyc();
    check("R6 A enable bits", a_rdata, 32'hC);
    check("R6 irq_a raised", {31'b0, irq_a}, 32'h1);
    drive(0, 1, 6'h10, 32'h8); cyc(); cyc();
    check("R6 irq_a dropped", {31'b0, irq_a}, 32'h0);

    // R6 timing on side B
    drive(1, 1, 6'h11, 32'h3); cyc();
    drive(0, 1, 6'h02, 32'h11); cyc();
    check("R6 irq_b not yet", {31'b0, irq_b}, 32'h0);
    cyc();
    check("R6 irq_b one cycle later", {31'b0, irq_b}, 32'h1);

    // R5 set beats clear in the same cycle
    drive(0, 1, 6'h02, 32'h12);
    drive(1, 1, 6'h10, 32'h2); cyc();
    drive(1, 0, 6'h10, 32'h0); cyc();
    check("R5 set wins", b_rdata, 32'h2);

    // R10 contested claim, R2 rvalid
    drive(0, 0, 6'h3F, 32'h0);
    drive(1, 0, 6'h3F, 32'h0); cyc();
    check("R10 A wins", a_rdata, 32'h0);
    check("R10 B loses", b_rdata, 32'h1);
    check("R2 rvalid both", {30'b0, a_rvalid, b_rvalid}, 32'h3);
    cyc();
    check("R2 rvalid drops", {30'b0, a_rvalid, b_rvalid}, 32'h0);

    // R1 mid-run reset: lock 0x3F and flags cleared, words kept
    rst = 1'b1; cyc(); rst = 1'b0;
    check("R1 irq_b after reset", {31'b0, irq_b}, 32'h0);
    drive(1, 0, 6'h10, 32'h0); cyc();
    check("R1 flags cleared", b_rdata, 32'h0);
    drive(0, 0, 6'h3F, 32'h0); cyc();
    check("R1 lock freed", a_rdata, 32'h0);
    drive(0, 1, 6'h3F, 32'h0); cyc();
    drive(0, 0, 6'h06, 32'h0); cyc();
    check("R1 words kept", a_rdata, 32'h33);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule